// File: doc/BRIEF.md
# Clock Level Divider Matcher

This block picks the best source clock level for a requested output rate. A table of available source frequencies sits outside the block and is read through a simple address/data port. For each level in use, the block works out the smallest integer divider that does not push the divided rate above the request, which is the divider rounded up. It then measures how far the divided rate falls short of the request. The level with the smallest shortfall wins.

A search begins with a one-cycle start pulse that carries the requested rate, an exact-only flag and the number of levels in use. Levels are visited in rising index order, one after another, through a single shared sequential divider. The search stops at once when a level divides down to the request exactly. When it ends, the block raises a one-cycle done pulse. Alongside it the block gives an error flag, the chosen level index and that level's frequency. These results stay valid until the next accepted start.

With the exact-only flag set, a search that finds no exact divide reports an error. With the flag clear, the closest undershooting level is reported as a success. A request of zero, or a level count of zero, is rejected at once and no table read takes place.

Top module: `clk_level_matcher`

## Requirements
- R1: After reset, `done` and `fail` are 0, and `sel_idx`, `sel_freq` and `tbl_addr` are all 0.
- R2: For each level frequency F and request Q, the divider is D = ceil(F / Q) and the shortfall is Q - floor(F / D). The reported level is one whose shortfall is the smallest among the levels scanned.
- R3: A later level replaces the current best only when its shortfall is strictly smaller. When shortfalls are equal, the lowest index is kept.
- R4: A level with zero shortfall ends the search on that level. At `done`, `tbl_addr` still holds that level's index and no higher index has been read. If no level gives zero shortfall, `tbl_addr` holds `level_count - 1` at `done`.
- R5: With `exact_only` = 1 and no zero-shortfall level, the search ends with `fail` = 1. `sel_idx` and `sel_freq` still show the closest level found.
- R6: With `exact_only` = 0, the search always ends with `fail` = 0 and reports the closest undershooting level, even when its shortfall is not zero.
- R7: A start with `level_count` = 0 gives `done` = 1 and `fail` = 1 on the cycle after start. `sel_idx`, `sel_freq` and `tbl_addr` read 0, and no level is scanned.
- R8: A start with `req_freq` = 0 behaves like R7: `done` = 1 and `fail` = 1 on the next cycle, with no division.
- R9: `done` is high for exactly one cycle per search. `fail`, `sel_idx` and `sel_freq` keep their values after `done` until the next accepted start.
- R10: A `start` pulse that arrives while a search is running is ignored. The running search completes with the result of its own request.
- R11: Up to MAX_LEVELS (32) levels are scanned, and a winner at the last index (31) is found and reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a search (ignored while busy) |
| req_freq | input | FREQ_W | Requested output frequency |
| exact_only | input | 1 | Treat a non-exact best match as an error |
| level_count | input | CNT_W | Number of table levels in use (0 to MAX_LEVELS) |
| tbl_addr | output | IDX_W | Table read address (index of level being examined) |
| tbl_data | input | FREQ_W | Table frequency at `tbl_addr`, combinational read |
| done | output | 1 | One-cycle pulse when a search ends |
| fail | output | 1 | Error result of the last search |
| sel_idx | output | IDX_W | Chosen level index |
| sel_freq | output | FREQ_W | Frequency of the chosen level |

## Verification
The assertions rely on some assumptions about the inputs. `level_count` never exceeds MAX_LEVELS. `tbl_data` reflects `tbl_addr` within the same cycle. `start` is not pulsed again in the very cycle that `done` is high. The divider check also assumes that a nonzero denominator reaches it, which the control logic ensures by rejecting a zero request and clamping a zero divider to one.

The bench keeps to these assumptions. It serves the table from a combinational array and keeps every level count at or below 32. It waits for each `done` to clear before it starts the next search. The only start it issues during a search is the deliberate mid-search pulse of the R10 scenario.

// File: rtl/cdm_pkg.sv
package cdm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_DIV_A = 2'd2,
        ST_DIV_B = 2'd3
    } cdm_state_e;

endpackage

// File: rtl/cdm_divider.sv
module cdm_divider #(
    parameter int W = 33
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quot
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  num;
        logic [W-1:0]  den;
        logic [CW-1:0] cnt;
        logic          busy;
        logic          done;
    } div_t;

    div_t q, n;
    logic [W:0] shifted;
    logic [W:0] diff;

    always_comb begin
        n       = q;
        n.done  = 1'b0;
        shifted = {q.rem, q.quo[W-1]};
        diff    = shifted - {1'b0, q.den};
        if (start) begin
            n.rem  = '0;
            n.quo  = num;
            n.num  = num;
            n.den  = den;
            n.cnt  = CW'(W);
            n.busy = 1'b1;
        end else if (q.busy) begin
            if (!diff[W]) begin
                n.rem = diff[W-1:0];
                n.quo = {q.quo[W-2:0], 1'b1};
            end else begin
                n.rem = shifted[W-1:0];
                n.quo = {q.quo[W-2:0], 1'b0};
            end
            n.cnt = q.cnt - CW'(1);
            if (q.cnt == CW'(1)) begin
                n.busy = 1'b0;
                n.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign done = q.done;
    assign quot = q.quo;

    logic [2*W-1:0] prod;
    assign prod = {{W{1'b0}}, q.quo} * {{W{1'b0}}, q.den};

    AST_DIV_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.den != '0) |-> (prod <= {{W{1'b0}}, q.num} &&
                                     ({{W{1'b0}}, q.num} - prod) < {{W{1'b0}}, q.den})); // R2

endmodule

// File: rtl/cdm_best_keeper.sv
module cdm_best_keeper #(
    parameter int FREQ_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              cand_valid,
    input  logic [FREQ_W-1:0] cand_sf,
    input  logic [IDX_W-1:0]  cand_idx,
    input  logic [FREQ_W-1:0] cand_freq,
    output logic [FREQ_W:0]   best_sf,
    output logic [IDX_W-1:0]  best_idx,
    output logic [FREQ_W-1:0] best_freq
);
    localparam int SW = FREQ_W + 1;

    typedef struct packed {
        logic [SW-1:0]     sf;
        logic [IDX_W-1:0]  idx;
        logic [FREQ_W-1:0] freq;
    } best_t;

    best_t q, n;
    logic  better;

    always_comb begin
        n      = q;
        better = ({1'b0, cand_sf} < q.sf);
        if (clear) begin
            n.sf   = '1;
            n.idx  = '0;
            n.freq = '0;
        end else if (cand_valid && better) begin
            n.sf   = {1'b0, cand_sf};
            n.idx  = cand_idx;
            n.freq = cand_freq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sf   <= '1;
            q.idx  <= '0;
            q.freq <= '0;
        end else begin
            q <= n;
        end
    end

    assign best_sf   = q.sf;
    assign best_idx  = q.idx;
    assign best_freq = q.freq;

    AST_BEST_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> q.sf <= $past(q.sf)); // R3

endmodule

// File: rtl/clk_level_matcher.sv
module clk_level_matcher #(
    parameter int FREQ_W     = 32,
    parameter int MAX_LEVELS = 32,
    localparam int IDX_W     = $clog2(MAX_LEVELS),
    localparam int CNT_W     = $clog2(MAX_LEVELS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] req_freq,
    input  logic              exact_only,
    input  logic [CNT_W-1:0]  level_count,
    output logic [IDX_W-1:0]  tbl_addr,
    input  logic [FREQ_W-1:0] tbl_data,
    output logic              done,
    output logic              fail,
    output logic [IDX_W-1:0]  sel_idx,
    output logic [FREQ_W-1:0] sel_freq
);
    import cdm_pkg::*;

    localparam int DW = FREQ_W + 1;

    typedef struct packed {
        cdm_state_e        st;
        logic [FREQ_W-1:0] req;
        logic              exact;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [FREQ_W-1:0] ent;
        logic              done;
        logic              err;
    } ctl_t;

    ctl_t q, n;

    logic              div_start, div_done;
    logic [DW-1:0]     div_num, div_den, div_quot;
    logic              trk_clear, cand_valid;
    logic [FREQ_W-1:0] shortfall;
    logic [DW-1:0]     best_sf;

    cdm_divider #(.W(DW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quot  (div_quot)
    );

    cdm_best_keeper #(.FREQ_W(FREQ_W), .IDX_W(IDX_W)) u_best (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (trk_clear),
        .cand_valid (cand_valid),
        .cand_sf    (shortfall),
        .cand_idx   (q.idx),
        .cand_freq  (q.ent),
        .best_sf    (best_sf),
        .best_idx   (sel_idx),
        .best_freq  (sel_freq)
    );

    always_comb begin
        n          = q;
        n.done     = 1'b0;
        div_start  = 1'b0;
        div_num    = '0;
        div_den    = '0;
        trk_clear  = 1'b0;
        cand_valid = 1'b0;
        shortfall  = q.req - div_quot[FREQ_W-1:0];
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    n.req     = req_freq;
                    n.exact   = exact_only;
                    n.cnt     = level_count;
                    n.idx     = '0;
                    n.err     = 1'b0;
                    trk_clear = 1'b1;
                    if (level_count == '0 || req_freq == '0) begin
                        n.done = 1'b1;
                        n.err  = 1'b1;
                    end else begin
                        n.st = ST_LOAD;
                    end
                end
            end
            ST_LOAD: begin
                div_start = 1'b1;
                div_num   = {1'b0, tbl_data} + {1'b0, q.req} - DW'(1);
                div_den   = {1'b0, q.req};
                n.ent     = tbl_data;
                n.st      = ST_DIV_A;
            end
            ST_DIV_A: begin
                if (div_done) begin
                    div_start = 1'b1;
                    div_num   = {1'b0, q.ent};
                    div_den   = (div_quot == '0) ? DW'(1) : div_quot;
                    n.st      = ST_DIV_B;
                end
            end
            ST_DIV_B: begin
                if (div_done) begin
                    cand_valid = 1'b1;
                    if (shortfall == '0) begin
                        n.st   = ST_IDLE;
                        n.done = 1'b1;
                        n.err  = 1'b0;
                    end else if (CNT_W'(q.idx) == q.cnt - CNT_W'(1)) begin
                        n.st   = ST_IDLE;
                        n.done = 1'b1;
                        n.err  = q.exact;
                    end else begin
                        n.idx = q.idx + IDX_W'(1);
                        n.st  = ST_LOAD;
                    end
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= n;
        end
    end

    assign tbl_addr = q.idx;
    assign done     = q.done;
    assign fail     = q.err;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !start) |=> !q.done); // R9

    AST_EXACT_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !q.err && q.exact) |-> best_sf == '0); // R5

    AST_BAD_ARGS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && start && (req_freq == '0 || level_count == '0))
            |=> (q.done && q.err && q.st == ST_IDLE)); // R7

    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && start) |=> $stable(q.req)); // R10

endmodule

// File: tb/clk_level_matcher_test.sv
module clk_level_matcher_test;
    localparam int FW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [FW-1:0] req_freq = '0;
    logic          exact_only = 1'b0;
    logic [5:0]    level_count = '0;
    logic [4:0]    tbl_addr;
    logic [FW-1:0] tbl_data;
    logic          done, fail;
    logic [4:0]    sel_idx;
    logic [FW-1:0] sel_freq;

    logic [FW-1:0] tbl [32];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [4:0]  exp_idx, exp_addr;
    logic [31:0] exp_freq;
    logic        exp_err;

    always #10 clk = ~clk;

    assign tbl_data = tbl[tbl_addr];

    clk_level_matcher uut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_freq(req_freq),
        .exact_only(exact_only), .level_count(level_count),
        .tbl_addr(tbl_addr), .tbl_data(tbl_data), .done(done),
        .fail(fail), .sel_idx(sel_idx), .sel_freq(sel_freq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model(input logic [31:0] rq, input bit ex, input int cnt);
        logic [63:0] best, d, qt, sf;
        best = 64'hFFFF_FFFF_FFFF_FFFF;
        exp_idx = 0; exp_freq = 0; exp_addr = 0;
        if (cnt == 0 || rq == 0) begin
            exp_err = 1;
            return;
        end
        for (int i = 0; i < cnt; i++) begin
            exp_addr = 5'(i);
            d = (64'(tbl[i]) + 64'(rq) - 1) / 64'(rq);
            if (d == 0) d = 1;
            qt = 64'(tbl[i]) / d;
            sf = 64'(rq) - qt;
            if (sf < best) begin
                best = sf; exp_idx = 5'(i); exp_freq = tbl[i];
            end
            if (sf == 0) break;
        end
        exp_err = ex && (best != 0);
    endtask

    task automatic pulse_start(input logic [31:0] rq, input bit ex, input int cnt);
        @(negedge clk);
        req_freq = rq; exact_only = ex; level_count = 6'(cnt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (!done) check({tag, " timeout"}, 0, 1);
    endtask

    task automatic run_case(input string tag, input logic [31:0] rq, input bit ex, input int cnt);
        model(rq, ex, cnt);
        pulse_start(rq, ex, cnt);
        wait_done(tag);
        check({tag, " fail"}, 64'(fail), 64'(exp_err));
        check({tag, " sel_idx"}, 64'(sel_idx), 64'(exp_idx));
        check({tag, " sel_freq"}, 64'(sel_freq), 64'(exp_freq));
        check({tag, " tbl_addr R4"}, 64'(tbl_addr), 64'(exp_addr));
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 done", 64'(done), 0);
        check("R1 fail", 64'(fail), 0);
        check("R1 sel_idx", 64'(sel_idx), 0);
        check("R1 sel_freq", 64'(sel_freq), 0);
        check("R1 tbl_addr", 64'(tbl_addr), 0);
    endtask

    task automatic load_std;
        tbl[0] = 19200000; tbl[1] = 32000000; tbl[2] = 48000000; tbl[3] = 64000000;
        tbl[4] = 96000000; tbl[5] = 100000000; tbl[6] = 120000000; tbl[7] = 150000000;
    endtask

    task automatic t_closest;
        load_std();
        run_case("R2 R6 closest 7.3728M", 32'd7372800, 1'b0, 8);
        run_case("R2 above-all 200M", 32'd200000000, 1'b0, 8);
        check("R2 above-all idx", 64'(sel_idx), 7);
        run_case("R2 R6 req 1", 32'd1, 1'b0, 8);
    endtask

    task automatic t_exact_hit;
        load_std();
        run_case("R4 exact 16M", 32'd16000000, 1'b1, 8);
        check("R4 stop index", 64'(tbl_addr), 1);
    endtask

    task automatic t_exact_miss;
        load_std();
        run_case("R5 exact miss", 32'd7372800, 1'b1, 8);
        check("R5 fail set", 64'(fail), 1);
        run_case("R6 same non-exact", 32'd7372800, 1'b0, 8);
        check("R6 fail clear", 64'(fail), 0);
    endtask

    task automatic t_tie;
        tbl[0] = 10; tbl[1] = 20; tbl[2] = 30; tbl[3] = 20;
        run_case("R3 tie", 32'd7, 1'b0, 4);
        check("R3 earliest wins", 64'(sel_idx), 1);
    endtask

    task automatic t_bad_args;
        load_std();
        run_case("R2 prior", 32'd16000000, 1'b0, 8);
        pulse_start(32'd5000000, 1'b0, 0);
        check("R7 done next cycle", 64'(done), 1);
        check("R7 fail", 64'(fail), 1);
        check("R7 sel_idx", 64'(sel_idx), 0);
        check("R7 tbl_addr", 64'(tbl_addr), 0);
        @(negedge clk);
        pulse_start(32'd0, 1'b0, 8);
        check("R8 done next cycle", 64'(done), 1);
        check("R8 fail", 64'(fail), 1);
        check("R8 sel_freq", 64'(sel_freq), 0);
        @(negedge clk);
    endtask

    task automatic t_pulse_hold;
        logic [4:0] hi;
        logic [31:0] hf;
        load_std();
        model(32'd7372800, 1'b0, 8);
        pulse_start(32'd7372800, 1'b0, 8);
        wait_done("R9");
        hi = sel_idx; hf = sel_freq;
        @(negedge clk);
        check("R9 done low after one cycle", 64'(done), 0);
        repeat (5) @(negedge clk);
        check("R9 idx held", 64'(sel_idx), 64'(hi));
        check("R9 freq held", 64'(sel_freq), 64'(hf));
        check("R9 idx value", 64'(sel_idx), 64'(exp_idx));
    endtask

    task automatic t_busy_start;
        load_std();
        model(32'd7372800, 1'b0, 8);
        pulse_start(32'd7372800, 1'b0, 8);
        repeat (30) @(negedge clk);
        start = 1'b1; req_freq = 32'd16000000; level_count = 6'd0;
        @(negedge clk);
        start = 1'b0;
        check("R10 no early done", 64'(done), 0);
        wait_done("R10");
        check("R10 idx", 64'(sel_idx), 64'(exp_idx));
        check("R10 freq", 64'(sel_freq), 64'(exp_freq));
        check("R10 fail", 64'(fail), 0);
        @(negedge clk);
    endtask

    task automatic t_full;
        for (int i = 0; i < 31; i++) tbl[i] = 32'(1000 + 2 * i);
        tbl[31] = 32'd2991;
        run_case("R11 last exact", 32'd997, 1'b1, 32);
        check("R11 idx 31", 64'(sel_idx), 31);
        run_case("R11 31 levels", 32'd997, 1'b1, 31);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) tbl[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_closest();
        t_exact_hit();
        t_exact_miss();
        t_tie();
        t_bad_args();
        t_pulse_hold();
        t_busy_start();
        t_full();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule